// File: doc/BRIEF.md
# Read Clock Window Phase Detector

This block is the digital phase comparator inside a floppy-disk data separator. Each leading (falling) edge of the active-low raw read data is compared with the current position inside the read clock window. The result is one of three outcomes: a request for a higher VCO frequency, a request for a lower one, or no request at all. The two pump outputs each carry a separate drive enable, so that the three-state behaviour of a shared correction line can be modelled without tri-state nets. The loop filter and the VCO lie outside the block.

The block clock runs at eight times the window rate. A rising edge of the window input starts a new window, and a position counter then splits that window into early, centred and late portions. A correction stays asserted from the cycle after the decision until the next window start. The detector operates only while the VFO enable (active low) is asserted and the write gate is off.

Top module: `rd_window_phase_det`

## Requirements
- R1: While reset is held, and afterwards until the first read edge, both drive enables are 0, pump_up is 0 and pump_dn_n is 1.
- R2: A read edge classified in window position 0, 1 or 2 makes pump_up_oe and pump_up 1 from the next cycle, with pump_dn_oe 0.
- R3: A read edge classified in window position 5, 6 or 7 makes pump_dn_oe 1 and pump_dn_n 0 from the next cycle, with pump_up_oe 0.
- R4: A read edge classified in window position 3 or 4 leaves both drive enables at 0, and it cancels any correction still being held.
- R5: A correction holds until the clock edge that samples a rising edge of rclk_win, and is released after that edge unless a new read edge is decided in the same cycle.
- R6: While vfo_en_n is 1 or wr_gate is 1, both drive enables are 0 one cycle later, any held correction is dropped, and read edges are ignored.
- R7: rd_data_n passes through two synchronising flops, and a falling edge is decided on the third clock edge after it is first sampled, using the window position held in that cycle. A low level of any length produces exactly one decision.
- R8: pump_up_oe and pump_dn_oe are never 1 together, and a later read edge in the same window replaces the earlier correction.
- R9: The window position resets to 0 on the edge that samples rclk_win rising. It then counts up by one per clock and saturates at 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, eight times the window rate |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_data_n | input | 1 | Raw read data pulses, active low, asynchronous |
| rclk_win | input | 1 | Read clock window; a rising edge starts a window |
| vfo_en_n | input | 1 | VFO enable, active low |
| wr_gate | input | 1 | Write gate; high disables detection |
| pump_up | output | 1 | Pump-up value, 1 while driven |
| pump_up_oe | output | 1 | Drive enable of pump_up |
| pump_dn_n | output | 1 | Pump-down value, 0 while driven |
| pump_dn_oe | output | 1 | Drive enable of pump_dn_n |

## Verification
The hardest cases to reach from the ports are those where a synchronised read edge lands in the same cycle as a window start, or where two edges fall in one window. The reason is that the synchroniser delay moves every edge three cycles from the point where it was driven. The stimulus therefore sweeps a short pulse through all eight phase offsets of the free-running window. It also sends closely spaced pulse pairs and one very long low level. The bench reference model tracks each input sample in a queue and tracks the window position as an integer, so every offset, including the collisions, is compared on every clock.

// File: rtl/rpd_pkg.sv
// Shared types and helpers for the read window phase detector.
// Assumes the window is divided into an integer number of position slots.
package rpd_pkg;

    typedef enum logic [1:0] {
        PH_CENTRE = 2'd0,
        PH_EARLY  = 2'd1,
        PH_LATE   = 2'd2
    } phase_e;

    // Maps a window position to early, centred or late; the outer thirds are equal in size.
    function automatic phase_e classify(input int unsigned pos, input int unsigned slots);
        int unsigned edge_len;
        edge_len = (slots + 1) / 3;
        if (pos < edge_len)
            return PH_EARLY;
        else if (pos >= slots - edge_len)
            return PH_LATE;
        else
            return PH_CENTRE;
    endfunction

endpackage

// File: rtl/rpd_edge_sync.sv
// Brings the asynchronous active-low read data into the clock domain and
// flags each falling edge with a one-cycle pulse.
// Assumes the input idles high; SYNC_STAGES flops precede the edge detector.
module rpd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    output logic fall
);
    localparam int TAPS = SYNC_STAGES + 1;

    logic [TAPS-1:0] shreg;

    // Shift chain: synchronising stages followed by one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '1;
        else
            shreg <= {shreg[TAPS-2:0], rd_n};
    end

    // Falling edge: the older sample is high and the newer one is low.
    assign fall = shreg[TAPS-1] & ~shreg[TAPS-2];

endmodule

// File: rtl/rpd_window_pos.sv
// Tracks the position inside the read clock window. A rising edge of the
// window input restarts the count; the count saturates at the last slot.
// Assumes the window input is already synchronous to clk.
module rpd_window_pos #(
    parameter int SLOTS = 8,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_in,
    output logic          win_start,
    output logic [SW-1:0] pos
);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    logic win_q;

    // Window start: window input high now but low on the previous edge.
    assign win_start = win_in & ~win_q;

    // Previous window level and position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            pos   <= LAST;
        end else begin
            win_q <= win_in;
            if (win_start)
                pos <= '0;
            else if (pos != LAST)
                pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/rpd_pump_ctrl.sv
// Turns each read edge into a pump-up, pump-down or no-change decision and
// holds it until the next window start. Disable clears everything at once.
// Assumes pos is the registered position valid in the decision cycle.
module rpd_pump_ctrl #(
    parameter int SLOTS = 8,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          rd_fall,
    input  logic          win_start,
    input  logic [SW-1:0] pos,
    output logic          up_q,
    output logic          dn_q
);
    import rpd_pkg::*;

    phase_e ph;

    // Classification of the current position.
    assign ph = classify(32'(pos), SLOTS);

    // Decision and hold register: a new edge wins over the window release.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (rd_fall) begin
            up_q <= (ph == PH_EARLY);
            dn_q <= (ph == PH_LATE);
        end else if (win_start) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rd_window_phase_det.sv
// Top of the read window phase detector: synchroniser, window position
// tracker and pump decision. Pump outputs carry separate drive enables.
// Assumes clk runs at SLOTS times the window rate.
module rd_window_phase_det #(
    parameter int SLOTS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_data_n,
    input  logic rclk_win,
    input  logic vfo_en_n,
    input  logic wr_gate,
    output logic pump_up,
    output logic pump_up_oe,
    output logic pump_dn_n,
    output logic pump_dn_oe
);
    localparam int SW = $clog2(SLOTS);

    logic          rd_fall;
    logic          win_start;
    logic [SW-1:0] pos;
    logic          enable;
    logic          up_q;
    logic          dn_q;

    // Detection runs only with the VFO enabled and writing off.
    assign enable = ~vfo_en_n & ~wr_gate;

    rpd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_n  (rd_data_n),
        .fall  (rd_fall)
    );

    rpd_window_pos #(.SLOTS(SLOTS)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_in    (rclk_win),
        .win_start (win_start),
        .pos       (pos)
    );

    rpd_pump_ctrl #(.SLOTS(SLOTS)) u_pump (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .rd_fall   (rd_fall),
        .win_start (win_start),
        .pos       (pos),
        .up_q      (up_q),
        .dn_q      (dn_q)
    );

    // Output drive: values are only meaningful while their enables are set.
    assign pump_up    = up_q;
    assign pump_up_oe = up_q;
    assign pump_dn_n  = ~dn_q;
    assign pump_dn_oe = dn_q;

endmodule

// File: rtl/rd_window_phase_det_chk.sv
// Property checker for the read window phase detector, bound to the top.
// Relates the pump drive enables to the decoded edges and window position.
module rd_window_phase_det_chk #(
    parameter int SLOTS = 8,
    localparam int SW = $clog2(SLOTS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vfo_en_n,
    input logic          wr_gate,
    input logic          pump_up_oe,
    input logic          pump_dn_oe,
    input logic          rd_fall,
    input logic          win_start,
    input logic [SW-1:0] pos
);
    localparam logic [SW-1:0] EDGE_LEN   = SW'((SLOTS + 1) / 3);
    localparam logic [SW-1:0] LATE_FIRST = SW'(SLOTS - (SLOTS + 1) / 3);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up_oe && pump_dn_oe));

    p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vfo_en_n || wr_gate) |=> (!pump_up_oe && !pump_dn_oe));

    p_up_from_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_up_oe) |-> ($past(rd_fall) && $past(pos) < EDGE_LEN));

    p_dn_from_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_dn_oe) |-> ($past(rd_fall) && $past(pos) >= LATE_FIRST));

    p_release_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_up_oe) |-> ($past(win_start) || $past(rd_fall) || $past(vfo_en_n) || $past(wr_gate)));

    p_restart_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> (pos == '0));

endmodule

bind rd_window_phase_det rd_window_phase_det_chk #(.SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vfo_en_n   (vfo_en_n),
    .wr_gate    (wr_gate),
    .pump_up_oe (pump_up_oe),
    .pump_dn_oe (pump_dn_oe),
    .rd_fall    (rd_fall),
    .win_start  (win_start),
    .pos        (pos)
);

// File: tb/rd_window_phase_det_tb_top.sv
// Bench for the read window phase detector: a behavioural reference model
// is updated on each rising edge and compared on each falling edge.
module rd_window_phase_det_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_data_n = 1'b1;
    logic rclk_win = 1'b0;
    logic vfo_en_n = 1'b0;
    logic wr_gate = 1'b0;
    logic pump_up, pump_up_oe, pump_dn_n, pump_dn_oe;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    int wcnt = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // Reference model state
    int  rd_hist[$] = '{1, 1, 1, 1};
    int  m_pos = 7;
    int  m_prev_win = 0;
    bit  m_up = 1'b0;
    bit  m_dn = 1'b0;

    rd_window_phase_det dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_data_n  (rd_data_n),
        .rclk_win   (rclk_win),
        .vfo_en_n   (vfo_en_n),
        .wr_gate    (wr_gate),
        .pump_up    (pump_up),
        .pump_up_oe (pump_up_oe),
        .pump_dn_n  (pump_dn_n),
        .pump_dn_oe (pump_dn_oe)
    );

    always #10 clk = ~clk;

    // Reference model: rd sampled three edges back high, two back low means a read edge.
    always @(posedge clk) begin
        bit fall, rise, en;
        int old_pos;
        cycles++;
        if (!rst_n) begin
            rd_hist = '{1, 1, 1, 1};
            m_pos = 7; m_prev_win = 0; m_up = 0; m_dn = 0;
        end else begin
            rd_hist.push_front(int'(rd_data_n));
            void'(rd_hist.pop_back());
            fall = (rd_hist[3] == 1) && (rd_hist[2] == 0);
            rise = rclk_win && (m_prev_win == 0);
            en = !vfo_en_n && !wr_gate;
            old_pos = m_pos;
            m_prev_win = int'(rclk_win);
            m_pos = rise ? 0 : ((m_pos < 7) ? m_pos + 1 : 7);
            if (!en) begin
                m_up = 0; m_dn = 0;
            end else if (fall) begin
                m_up = (old_pos <= 2);
                m_dn = (old_pos >= 5);
            end else if (rise) begin
                m_up = 0; m_dn = 0;
            end
        end
    end

    // Compare on every falling edge after the first rising edge.
    always @(negedge clk) begin
        if (cycles > 0 && !done) begin
            vectors++;
            if (pump_up_oe !== m_up || pump_up !== m_up ||
                pump_dn_oe !== m_dn || pump_dn_n !== !m_dn) begin
                errors++;
                $display("FAIL %s t=%0t: up=%b up_oe=%b dn_n=%b dn_oe=%b exp up=%b up_oe=%b dn_n=%b dn_oe=%b",
                         cur_req, $time, pump_up, pump_up_oe, pump_dn_n, pump_dn_oe,
                         m_up, m_up, !m_dn, m_dn);
            end
        end
    end

    // Free-running window: four cycles high, four low.
    always @(negedge clk) begin
        wcnt = (wcnt + 1) % 8;
        rclk_win = (wcnt < 4);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int low_len);
        rd_data_n = 1'b0;
        idle(low_len);
        rd_data_n = 1'b1;
    endtask

    // Watchdog: an overlong run is a failed check.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        idle(5);
        rst_n = 1'b1;
        idle(12);

        // Sweep a short pulse across every window offset
        cur_req = "R2 R3 R4 R9";
        for (int k = 0; k < 24; k++) begin
            pulse(1);
            idle(8 + (k % 8));
        end

        // Hold then release at the window start
        cur_req = "R5";
        for (int k = 0; k < 8; k++) begin
            pulse(2);
            idle(21 + k);
        end

        // Two edges in one window: the later one replaces the first
        cur_req = "R8";
        for (int k = 0; k < 16; k++) begin
            pulse(1);
            idle(1 + (k % 4));
            pulse(1);
            idle(11 + (k % 5));
        end

        // Long low level: one decision only
        cur_req = "R7";
        pulse(40);
        idle(20);
        pulse(3);
        idle(30);

        // Disable while holding, and pulses ignored while disabled
        cur_req = "R6";
        for (int k = 0; k < 8; k++) begin
            pulse(1);
            idle(3 + k % 3);
            vfo_en_n = 1'b1;
            idle(2);
            pulse(1);
            idle(6);
            vfo_en_n = 1'b0;
            idle(9);
            pulse(1);
            idle(2 + k);
            wr_gate = 1'b1;
            pulse(1);
            idle(7);
            wr_gate = 1'b0;
            idle(10);
        end

        // Reset mid-correction returns to idle
        cur_req = "R1";
        pulse(1);
        idle(4);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule